// File: doc/BRIEF.md
# Reloadable 16-bit Down Counter with Pulse Modes

The block is a 16-bit down counter paired with a reload register. Software reaches it over an 8-bit register port. The counter is split across a low-byte address and a high-byte address, and a third address holds a small control register.

When the counter reaches zero, the next count event reloads it from the reload register and raises a sticky interrupt request. The control register selects one of four counting modes:

- a free timer driven by an external count-enable tick;
- the same timer, with a toggle output that flips on each reload;
- an edge counter on an asynchronous input pin;
- a pulse-width meter, where the tick is counted only while that pin sits at a chosen level.

Sixteen-bit values move through the 8-bit port in a fixed byte order. A low-byte write is parked until the high byte arrives. A high-byte read freezes the low byte for the read that follows. Software must therefore write low then high, and read high then low. A control bit decides whether a committed write also lands in the running counter or only in the reload register.

Top module: `tmr16_reload`

## Requirements
- R1: Synchronous reset clears `irq`, `pulse_out`, `pulse_oe`, `rdata` and the control register, and sets both the counter and the reload register to all ones.
- R2: Each count event with the counter non-zero decrements the counter by exactly one.
- R3: A count event with the counter at zero reloads the counter from the reload register. Outside the pulse-width mode it also sets `irq` at the same clock edge.
- R4: `irq` stays set until a cycle with `irq_clr` high. If a set condition and `irq_clr` meet in the same cycle, `irq` stays set.
- R5: Address 0 writes park the low byte. An address 1 write commits {wdata, parked byte} to the reload register. The same write also loads the counter when control bit 4 is 0, and leaves the counter untouched when bit 4 is 1.
- R6: A read returns its byte on `rdata` one cycle after `rd_en`, and `rdata` holds that value until the next read. Address 1 returns counter bits 15:8 and captures bits 7:0 at the same moment. Address 0 returns that captured byte, even if the counter has moved since.
- R7: While control bit 3 (halt) is 1, no count event occurs and the counter keeps its value.
- R8: With mode field (control bits 1:0) = 01, `pulse_out` inverts at every reload and holds otherwise. `pulse_oe` is 1 exactly one cycle after the mode field reads 01, and 0 otherwise.
- R9: With mode field 10, the count events are the edges of `ext_in`, seen after a two-flop synchronizer. Control bit 2 = 0 counts rising edges and bit 2 = 1 counts falling edges. `cnt_en` is ignored in this mode.
- R10: With mode field 11, `cnt_en` ticks count only while the synchronized `ext_in` is high (bit 2 = 0) or low (bit 2 = 1). `irq` is set when the input leaves that level, and a reload in this mode does not set `irq`.
- R11: A counter load by an address 1 write takes priority over a count event in the same cycle.
- R12: The control register is read and written at address 2 through bits 4:0. Bits 7:5 read as 0, and address 3 reads as 0. Mode field encodings are: 00 timer, 01 pulse output, 10 edge counting, 11 width measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Prescaled count-enable tick |
| ext_in | input | 1 | Asynchronous event / gate pin |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_clr | input | 1 | Write-one-to-clear strobe for `irq` |
| irq | output | 1 | Sticky interrupt request |
| pulse_out | output | 1 | Toggle output |
| pulse_oe | output | 1 | High while the toggle output is selected |

## Verification
The assertions check on every cycle that the counter follows the counter rules:

- a decrement on a count event;
- a reload from the reload register on a zero count event;
- no movement while halted;
- a load taking priority over a count event.

They also check that `irq` rises only from a reload or a closing edge and then stays up until cleared, and that `pulse_out` changes only on a reload in pulse mode.

Some behaviours only the bench scenarios can show, because they depend on a sequence of bus operations or pin activity. These are the byte-ordered access (a parked low byte, and a frozen low byte surviving later counting), the choice between latch-only and latch-plus-counter writes, the edge polarity and the synchronizer delay in edge counting, and the gated count and closing-edge interrupt of width measurement.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_PULSE = 2'd1,
    MODE_EVENT = 2'd2,
    MODE_WIDTH = 2'd3
  } tmr_mode_e;

  // Control register layout, bit 4 down to bit 0
  typedef struct packed {
    logic      latch_only;  // 1: high-byte write updates only the reload register
    logic      halt;        // 1: counting frozen
    logic      edge_sel;    // 0: rising edge / high level, 1: falling edge / low level
    tmr_mode_e mode;
  } tmr_ctl_t;

  localparam int CTL_W = $bits(tmr_ctl_t);

  localparam int SEL_LO  = 0;
  localparam int SEL_HI  = 1;
  localparam int SEL_CTL = 2;

endpackage

// File: rtl/tmr16_sync_edge.sv
module tmr16_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic prev
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign level = sh[STAGES-1];
  assign prev  = sh[STAGES];
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 2,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  output tmr_ctl_t          ctl,
  output logic [CNT_W-1:0]  latch,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [BUS_W-1:0]  rdata
);
  logic [BUS_W-1:0] lo_buf;
  logic [BUS_W-1:0] lo_snap;
  logic hit_lo, hit_hi, hit_ctl;

  assign hit_lo  = (addr == ADDR_W'(SEL_LO));
  assign hit_hi  = (addr == ADDR_W'(SEL_HI));
  assign hit_ctl = (addr == ADDR_W'(SEL_CTL));

  assign load_val = {wdata, lo_buf};
  assign load     = wr_en & hit_hi & ~ctl.latch_only;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_buf  <= '0;
      lo_snap <= '0;
      latch   <= '1;
      ctl     <= '0;
      rdata   <= '0;
    end else begin
      if (wr_en && hit_lo)  lo_buf <= wdata;
      if (wr_en && hit_hi)  latch  <= {wdata, lo_buf};
      if (wr_en && hit_ctl) ctl    <= tmr_ctl_t'(wdata[CTL_W-1:0]);
      if (rd_en) begin
        if (hit_lo) begin
          rdata <= lo_snap;
        end else if (hit_hi) begin
          rdata   <= count[CNT_W-1:BUS_W];
          lo_snap <= count[BUS_W-1:0];
        end else if (hit_ctl) begin
          rdata <= {{(BUS_W-CTL_W){1'b0}}, ctl};
        end else begin
          rdata <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] latch,
  input  tmr_mode_e        mode,
  input  logic             close_edge,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count,
  output logic             underflow,
  output logic             irq,
  output logic             pulse_out,
  output logic             pulse_oe
);
  logic irq_set;

  assign underflow = tick & ~load & (count == '0);
  assign irq_set   = (underflow & (mode != MODE_WIDTH)) | close_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '1;
      irq       <= 1'b0;
      pulse_out <= 1'b0;
      pulse_oe  <= 1'b0;
    end else begin
      if (load)           count <= load_val;
      else if (underflow) count <= latch;
      else if (tick)      count <= count - CNT_W'(1);

      if (irq_set)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;

      if (underflow && mode == MODE_PULSE) pulse_out <= ~pulse_out;
      pulse_oe <= (mode == MODE_PULSE);
    end
  end
endmodule

// File: rtl/tmr16_reload.sv
module tmr16_reload
  import tmr16_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              ext_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              irq_clr,
  output logic              irq,
  output logic              pulse_out,
  output logic              pulse_oe
);
  localparam int CNT_W = 2 * BUS_W;

  tmr_ctl_t         ctl;
  tmr_mode_e        mode_w;
  logic             halt_w;
  logic [CNT_W-1:0] count, latch, load_val;
  logic             load, tick, raw_tick, underflow, close_edge;
  logic             ext_lvl, ext_prev, act_now, act_prev;

  assign mode_w = ctl.mode;
  assign halt_w = ctl.halt;

  tmr16_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ext_in), .level(ext_lvl), .prev(ext_prev)
  );

  tmr16_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .count(count), .ctl(ctl), .latch(latch),
    .load(load), .load_val(load_val), .rdata(rdata)
  );

  // selected level: high when edge_sel is 0, low when it is 1
  assign act_now    = ext_lvl ^ ctl.edge_sel;
  assign act_prev   = ext_prev ^ ctl.edge_sel;
  assign close_edge = (mode_w == MODE_WIDTH) & act_prev & ~act_now;

  always_comb begin
    unique case (mode_w)
      MODE_EVENT: raw_tick = act_now & ~act_prev;
      MODE_WIDTH: raw_tick = cnt_en & act_now;
      default:    raw_tick = cnt_en;
    endcase
  end
  assign tick = raw_tick & ~halt_w;

  tmr16_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .load_val(load_val),
    .latch(latch), .mode(mode_w), .close_edge(close_edge), .irq_clr(irq_clr),
    .count(count), .underflow(underflow), .irq(irq),
    .pulse_out(pulse_out), .pulse_oe(pulse_oe)
  );
endmodule

// File: rtl/tmr16_reload_chk.sv
module tmr16_reload_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             load,
  input logic             underflow,
  input logic             halt,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] latch,
  input logic [CNT_W-1:0] load_val,
  input logic             close_edge,
  input logic             irq_clr,
  input logic             irq,
  input logic             pulse_out,
  input logic             pulse_oe
);
  assert_decrement_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && count != '0) |=> (count == $past(count) - CNT_W'(1)));

  assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
    underflow |=> (count == $past(latch)));

  assert_irq_on_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (underflow && mode != 2'd3) |=> irq);

  assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  assert_irq_cleared_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !underflow && !close_edge) |=> !irq);

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(underflow || close_edge));

  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (halt && !load) |=> $stable(count));

  assert_pulse_toggle_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(pulse_out) |-> $past(underflow && mode == 2'd1));

  assert_pulse_oe_R8: assert property (@(posedge clk) disable iff (rst)
    pulse_oe |-> ($past(mode) == 2'd1));

  assert_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val)));
endmodule

bind tmr16_reload tmr16_reload_chk #(.CNT_W(2 * BUS_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .load(load), .underflow(underflow),
  .halt(halt_w), .mode(mode_w), .count(count), .latch(latch),
  .load_val(load_val), .close_edge(close_edge), .irq_clr(irq_clr),
  .irq(irq), .pulse_out(pulse_out), .pulse_oe(pulse_oe)
);

// File: tb/tmr16_reload_tb.sv
module tmr16_reload_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0, ext_in = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, irq_clr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, pulse_out, pulse_oe;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tmr16_reload u_dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .ext_in(ext_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_clr(irq_clr), .irq(irq), .pulse_out(pulse_out), .pulse_oe(pulse_oe)
  );

  // ---------------- behavioural reference ----------------
  logic [15:0] m_cnt, m_latch;
  logic [7:0]  m_lo_buf, m_snap, m_rdata;
  logic [4:0]  m_ctl;
  logic        m_irq, m_pulse, m_oe;
  logic        ext_hist[$];
  logic        m_act, m_pact, m_tk, m_ld, m_uf, m_cls;
  logic [1:0]  m_md;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 16'hFFFF; m_latch = 16'hFFFF;
      m_lo_buf = 8'h00; m_snap = 8'h00; m_rdata = 8'h00;
      m_ctl = 5'h00; m_irq = 1'b0; m_pulse = 1'b0; m_oe = 1'b0;
      ext_hist = {1'b0, 1'b0, 1'b0};
    end else begin
      m_md   = m_ctl[1:0];
      m_act  = ext_hist[1] ^ m_ctl[2];
      m_pact = ext_hist[2] ^ m_ctl[2];
      case (m_md)
        2'd2:    m_tk = m_act && !m_pact;
        2'd3:    m_tk = cnt_en && m_act;
        default: m_tk = cnt_en;
      endcase
      if (m_ctl[3]) m_tk = 1'b0;
      m_ld  = wr_en && addr == 2'd1 && !m_ctl[4];
      m_uf  = m_tk && !m_ld && m_cnt == 16'd0;
      m_cls = m_md == 2'd3 && m_pact && !m_act;
      if ((m_uf && m_md != 2'd3) || m_cls) m_irq = 1'b1;
      else if (irq_clr)                    m_irq = 1'b0;
      if (m_uf && m_md == 2'd1) m_pulse = !m_pulse;
      m_oe = (m_md == 2'd1);
      if (rd_en) begin
        case (addr)
          2'd0: m_rdata = m_snap;
          2'd1: begin m_rdata = m_cnt[15:8]; m_snap = m_cnt[7:0]; end
          2'd2: m_rdata = {3'b000, m_ctl};
          default: m_rdata = 8'h00;
        endcase
      end
      if (m_ld)               m_cnt = {wdata, m_lo_buf};
      else if (m_uf)          m_cnt = m_latch;
      else if (m_tk)          m_cnt = m_cnt - 16'd1;
      if (wr_en) begin
        case (addr)
          2'd0: m_lo_buf = wdata;
          2'd1: m_latch  = {wdata, m_lo_buf};
          2'd2: m_ctl    = wdata[4:0];
          default: ;
        endcase
      end
      ext_hist.push_front(ext_in);
      void'(ext_hist.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      chk("R3/R4 irq vs model", {15'd0, irq}, {15'd0, m_irq});
      chk("R8 pulse_out vs model", {15'd0, pulse_out}, {15'd0, m_pulse});
      chk("R8 pulse_oe vs model", {15'd0, pulse_oe}, {15'd0, m_oe});
      chk("R6 rdata vs model", {8'd0, rdata}, {8'd0, m_rdata});
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] hi, lo;
    rd(2'd1, hi);
    rd(2'd0, lo);
    v = {hi, lo};
  endtask

  task automatic load16(input logic [15:0] v);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  task automatic ticks(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic ext_pulse(input int n);
    ext_in = 1'b1; idle(n);
    ext_in = 1'b0; idle(n);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    idle(4);
    rst = 1'b0;
    // R1: reset state
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 pulse_out", {15'd0, pulse_out}, 16'd0);
    chk("R1 pulse_oe", {15'd0, pulse_oe}, 16'd0);
    chk("R1 rdata", {8'd0, rdata}, 16'd0);
    cmp_on = 1'b1;
    rd_cnt(v); chk("R1 counter all ones", v, 16'hFFFF);

    // R5: parked low byte does not reach the counter
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h05);
    rd_cnt(v); chk("R5 low byte parked", v, 16'hFFFF);
    wr(2'd1, 8'h00);
    rd_cnt(v); chk("R5 commit loads counter", v, 16'h0005);

    // R6: frozen low byte survives later counting
    rd(2'd1, b); chk("R6 high byte", {8'd0, b}, 16'h0000);
    ticks(2);
    rd(2'd0, b); chk("R6 frozen low byte", {8'd0, b}, 16'h0005);

    // R2 / R3: count 3 down to 0, then reload
    ticks(3);
    rd_cnt(v); chk("R2 decrement to zero", v, 16'h0000);
    chk("R3 no irq before reload", {15'd0, irq}, 16'd0);
    ticks(1);
    chk("R3 irq on reload", {15'd0, irq}, 16'd1);
    rd_cnt(v); chk("R3 reloaded value", v, 16'h0005);
    idle(3);
    chk("R4 irq sticky", {15'd0, irq}, 16'd1);
    clr_irq();
    chk("R4 irq cleared", {15'd0, irq}, 16'd0);

    // R7: halt
    wr(2'd2, 8'h08);
    ticks(3);
    rd_cnt(v); chk("R7 halt holds counter", v, 16'h0005);
    rd(2'd2, b); chk("R12 control readback", {8'd0, b}, 16'h0008);

    // R5: latch-only writes
    wr(2'd2, 8'h10);
    load16(16'h0002);
    rd_cnt(v); chk("R5 latch-only keeps counter", v, 16'h0005);
    ticks(6);
    rd_cnt(v); chk("R5 latch-only value used at reload", v, 16'h0002);

    // R4: set wins over clear
    clr_irq();
    ticks(2);
    irq_clr = 1'b1; cnt_en = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0; cnt_en = 1'b0;
    chk("R4 set beats clear", {15'd0, irq}, 16'd1);

    // R11: load beats count event
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h07);
    cnt_en = 1'b1;
    wr(2'd1, 8'h00);
    cnt_en = 1'b0;
    rd_cnt(v); chk("R11 load wins over tick", v, 16'h0007);

    // R8: pulse output
    wr(2'd2, 8'h01);
    idle(1);
    chk("R8 oe in pulse mode", {15'd0, pulse_oe}, 16'd1);
    load16(16'h0001);
    ticks(2);
    chk("R8 first toggle", {15'd0, pulse_out}, 16'd1);
    ticks(1);
    chk("R8 holds between reloads", {15'd0, pulse_out}, 16'd1);
    ticks(1);
    chk("R8 second toggle", {15'd0, pulse_out}, 16'd0);
    wr(2'd2, 8'h00);
    idle(1);
    chk("R8 oe off in timer mode", {15'd0, pulse_oe}, 16'd0);

    // R9: edge counting
    wr(2'd2, 8'h02);
    load16(16'h0010);
    ticks(10);
    rd_cnt(v); chk("R9 cnt_en ignored", v, 16'h0010);
    for (int i = 0; i < 3; i++) ext_pulse(3);
    idle(4);
    rd_cnt(v); chk("R9 rising edges", v, 16'h000D);
    wr(2'd2, 8'h06);
    for (int i = 0; i < 2; i++) ext_pulse(3);
    idle(4);
    rd_cnt(v); chk("R9 falling edges", v, 16'h000B);

    // R10: pulse-width measurement
    wr(2'd2, 8'h03);
    load16(16'h0020);
    clr_irq();
    chk("R10 irq clear before pulse", {15'd0, irq}, 16'd0);
    cnt_en = 1'b1;
    ext_in = 1'b1; idle(10);
    ext_in = 1'b0; idle(5);
    cnt_en = 1'b0;
    chk("R10 irq on closing edge", {15'd0, irq}, 16'd1);
    rd_cnt(v); chk("R10 gated count", v, 16'h0016);
    clr_irq();
    load16(16'h0001);
    cnt_en = 1'b1;
    ext_in = 1'b1; idle(8);
    chk("R10 reload raises no irq", {15'd0, irq}, 16'd0);
    ext_in = 1'b0; idle(5);
    cnt_en = 1'b0;
    chk("R10 closing edge irq", {15'd0, irq}, 16'd1);

    // R12: unused control bits and address 3
    wr(2'd2, 8'hE8);
    rd(2'd2, b); chk("R12 upper bits read zero", {8'd0, b}, 16'h0008);
    rd(2'd3, b); chk("R12 address 3 reads zero", {8'd0, b}, 16'h0000);

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule